// File: doc/BRIEF.md
# Byte-wide CRC-16 remainder updater with split nibble tables

This block keeps a running 16-bit cyclic-redundancy remainder and folds in one 8-bit character in each clock cycle in which a character is offered. The generator polynomial is a parameter. Its `x^16` term is implied and every other coefficient `x^k` sits at bit k of the parameter. The default, 16'h8005, encodes x^16+x^15+x^2+1. Characters are taken most significant bit first, so bit 7 of `byte_in` is the first bit of that character on the line.

An update has three steps. First the character is XORed into the top byte of the remainder, which gives a working word. Then the low byte of the working word moves up into the high byte of the result, and the low byte of the result is zero. Finally the two nibbles of the working word's top byte each index their own 16-entry table of 16-bit words, and both table words are XORed into the result. The two tables are computed during elaboration from the polynomial parameter. A parameter can instead select a parity-per-bit form of the same product, built from a computed mask matrix.

A message begins with `init`. When `init` is given together with a character, that character is the first character of the new message. When all characters have been absorbed, the remainder is the check word. On the receive side, running the message and then its check word (high byte first) leaves a zero remainder.

Top module: `crc16_nib_updater`

## Requirements
- R1: After reset, `crc_out` reads 16'h0000.
- R2: When `byte_valid` is high and `init` is low, `crc_out` after the next rising edge equals the remainder of the previous `crc_out`, extended by the 8 character bits, divided by the polynomial. The character bits are taken bit 7 first, and bit k of POLY is the coefficient of x^k with x^16 implied.
- R3: When `init` is high and `byte_valid` is low, `crc_out` is 16'h0000 after the next rising edge.
- R4: When `init` and `byte_valid` are both high, `crc_out` after the next edge equals the R2 update of `byte_in` applied to a zero remainder. The old remainder has no effect.
- R5: When `init` and `byte_valid` are both low, `crc_out` does not change, whatever `byte_in` carries.
- R6: Feeding a message, then its resulting remainder as two characters (high byte first), leaves `crc_out` at 16'h0000.
- R7: The table form (USE_TABLE=1) and the parity form (USE_TABLE=0) give identical `crc_out` sequences.
- R8: A zero character absorbed into a zero remainder leaves the remainder zero.
- R9: With the default polynomial, the ASCII characters "123456789" absorbed after `init` give 16'hFEE8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| init | input | 1 | Start of message; clears the remainder, or seeds it from a character offered in the same cycle |
| byte_valid | input | 1 | A character is present on `byte_in` this cycle |
| byte_in | input | 8 | Character; bit 7 is the first bit on the line |
| crc_out | output | 16 | Current remainder |

## Verification
Long random character streams with sparse `init` and idle gaps are compared against a bit-serial division model. These streams separate a correct nibble split from a table built with the wrong nibble position or a wrong shift count. They also catch a missing byte move. Directed cases cover the rest. The digit string has a known check value, so it fixes the bit order and the polynomial orientation. Appending the check word tests the zero-syndrome property. Back-to-back `init` with and without a character distinguishes seeding from clearing. Idle cycles with a changing `byte_in` show that the hold condition ignores the data bus. A second instance built in the parity form runs the same stimulus and must agree cycle by cycle.

// File: rtl/crc16_nib_pkg.sv
package crc16_nib_pkg;
  localparam int CRC_W       = 16;
  localparam int BYTE_W      = 8;
  localparam int NIB_W       = 4;
  localparam int NIB_ENTRIES = 1 << NIB_W;
  localparam int HI_NIB_POS  = CRC_W - NIB_W;
  localparam int LO_NIB_POS  = CRC_W - BYTE_W;

  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [NIB_ENTRIES-1:0][CRC_W-1:0] nib_tbl_t;
  typedef logic [CRC_W-1:0][CRC_W-1:0] mask_mat_t;

  // Clock a register through the divider with no data input.
  function automatic crc_t lfsr_run(crc_t start, crc_t poly, int steps);
    crc_t v;
    v = start;
    for (int i = 0; i < steps; i++) begin
      if (v[CRC_W-1]) v = (v << 1) ^ poly;
      else            v = v << 1;
    end
    return v;
  endfunction

  // Table of one nibble of the top byte after one character time of shifting.
  function automatic nib_tbl_t nib_table(crc_t poly, int pos);
    nib_tbl_t t;
    for (int n = 0; n < NIB_ENTRIES; n++)
      t[n] = lfsr_run(crc_t'(n) << pos, poly, BYTE_W);
    return t;
  endfunction

  // Row k is the set of working-word bits whose parity forms result bit k.
  function automatic mask_mat_t parity_masks(crc_t poly);
    mask_mat_t m;
    crc_t      col;
    m = '0;
    for (int j = 0; j < CRC_W; j++) begin
      col = lfsr_run(crc_t'(1) << j, poly, BYTE_W);
      for (int k = 0; k < CRC_W; k++) m[k][j] = col[k];
    end
    return m;
  endfunction
endpackage

// File: rtl/crc_nib_lut.sv
module crc_nib_lut
  import crc16_nib_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY    = 16'h8005,
  parameter int               NIB_POS = HI_NIB_POS
) (
  input  logic [NIB_W-1:0] idx,
  output logic [CRC_W-1:0] word
);
  localparam nib_tbl_t TBL = nib_table(POLY, NIB_POS);

  assign word = TBL[idx];
endmodule

// File: rtl/crc_nib_next.sv
module crc_nib_next
  import crc16_nib_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY      = 16'h8005,
  parameter bit               USE_TABLE = 1'b1
) (
  input  logic [CRC_W-1:0]  rem_in,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  rem_out
);
  logic [CRC_W-1:0] work;

  assign work = rem_in ^ {data, {(CRC_W-BYTE_W){1'b0}}};

  generate
    if (USE_TABLE) begin : g_table
      logic [CRC_W-1:0] hi_term;
      logic [CRC_W-1:0] lo_term;

      crc_nib_lut #(.POLY(POLY), .NIB_POS(HI_NIB_POS)) hi_lut_i (
        .idx  (work[CRC_W-1 -: NIB_W]),
        .word (hi_term)
      );
      crc_nib_lut #(.POLY(POLY), .NIB_POS(LO_NIB_POS)) lo_lut_i (
        .idx  (work[LO_NIB_POS +: NIB_W]),
        .word (lo_term)
      );

      assign rem_out = {work[CRC_W-BYTE_W-1:0], {BYTE_W{1'b0}}} ^ hi_term ^ lo_term;
    end else begin : g_parity
      localparam mask_mat_t MASKS = parity_masks(POLY);
      for (genvar k = 0; k < CRC_W; k++) begin : g_bit
        assign rem_out[k] = ^(work & MASKS[k]);
      end
    end
  endgenerate

  // With a zero top byte there is no feedback: the result is a plain byte move (R2).
  always_comb begin
    if (work[CRC_W-1 -: BYTE_W] == '0) begin
      assert_plain_move_R2: assert (rem_out == {work[CRC_W-BYTE_W-1:0], {BYTE_W{1'b0}}});
    end
  end
endmodule

// File: rtl/crc16_nib_updater.sv
module crc16_nib_updater
  import crc16_nib_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY      = 16'h8005,
  parameter bit               USE_TABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_out
);
  // Reset: asserted at once, released two edges later.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] base_rem;
  logic [CRC_W-1:0] upd_rem;
  logic             load_en;

  assign base_rem = init ? '0 : crc_q;

  crc_nib_next #(.POLY(POLY), .USE_TABLE(USE_TABLE)) next_i (
    .rem_in  (base_rem),
    .data    (byte_in),
    .rem_out (upd_rem)
  );

  always_comb begin
    load_en = init | byte_valid;
    crc_d   = crc_q;
    if (byte_valid) crc_d = upd_rem;
    else if (init)  crc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  crc_q <= '0;
    else if (load_en) crc_q <= crc_d;
  end

  assign crc_out = crc_q;

  assert_init_clears_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (init && !byte_valid) |=> (crc_out == '0));

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!init && !byte_valid) |=> $stable(crc_out));

  assert_zero_stays_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!init && byte_valid && byte_in == '0 && crc_out == '0) |=> (crc_out == '0));

  assert_seed_ignores_old_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (init && byte_valid && byte_in == '0) |=> (crc_out == '0));
endmodule

// File: tb/crc16_nib_updater_tb_top.sv
module crc16_nib_updater_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] POLY       = 16'h8005;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic [15:0] crc_tab;
  logic [15:0] crc_par;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] model = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_nib_updater #(.POLY(POLY), .USE_TABLE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .init(init), .byte_valid(byte_valid),
    .byte_in(byte_in), .crc_out(crc_tab)
  );

  crc16_nib_updater #(.POLY(POLY), .USE_TABLE(1'b0)) dut_bw_i (
    .clk(clk), .rst_n(rst_n), .init(init), .byte_valid(byte_valid),
    .byte_in(byte_in), .crc_out(crc_par)
  );

  function automatic logic [15:0] serial_update(logic [15:0] r, logic [7:0] b);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r  = r << 1;
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [15:0] actual, logic [15:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  // Drive one cycle at the falling edge; outputs are read at the next falling edge.
  task automatic cycle(logic v, logic i, logic [7:0] b);
    byte_valid = v;
    init       = i;
    byte_in    = b;
    @(negedge clk);
    if (i)      model = v ? serial_update(16'h0000, b) : 16'h0000;
    else if (v) model = serial_update(model, b);
  endtask

  task automatic step_check(string tag, logic v, logic i, logic [7:0] b);
    cycle(v, i, b);
    check(tag, crc_tab, model);
    check("R7", crc_par, crc_tab);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap;
    string digits;
    void'($urandom(32'd1971));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", crc_tab, 16'h0000);
    check("R1", crc_par, 16'h0000);

    // R9: digit string check value, bit 7 first
    digits = "123456789";
    step_check("R4", 1'b1, 1'b1, digits[0]);
    for (int k = 1; k < 9; k++) step_check("R2", 1'b1, 1'b0, digits[k]);
    check("R9", crc_tab, 16'hFEE8);

    // R5: idle cycles with a moving data bus
    snap = crc_tab;
    for (int k = 0; k < 4; k++) step_check("R5", 1'b0, 1'b0, 8'(k * 37 + 5));
    check("R5", crc_tab, snap);

    // R6: append the check word
    snap = model;
    step_check("R6", 1'b1, 1'b0, snap[15:8]);
    step_check("R6", 1'b1, 1'b0, snap[7:0]);
    check("R6", crc_tab, 16'h0000);

    // R3 and R4: clear, then seed over a non-zero remainder
    step_check("R2", 1'b1, 1'b0, 8'hA5);
    step_check("R3", 1'b0, 1'b1, 8'hFF);
    check("R3", crc_tab, 16'h0000);
    step_check("R2", 1'b1, 1'b0, 8'h3C);
    step_check("R4", 1'b1, 1'b1, 8'h80);
    check("R4", crc_tab, serial_update(16'h0000, 8'h80));

    // R8: zero characters from zero
    step_check("R3", 1'b0, 1'b1, 8'h00);
    for (int k = 0; k < 3; k++) step_check("R8", 1'b1, 1'b0, 8'h00);
    check("R8", crc_tab, 16'h0000);

    // Random streams with sparse init and gaps
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] rb;
      logic rv, ri;
      rb = 8'($urandom);
      rv = ($urandom % 4) != 0;
      ri = ($urandom % 40) == 0;
      step_check("R2", rv, ri, rb);
      if ((n % 500) == 499) begin
        snap = model;
        step_check("R6", 1'b1, 1'b0, snap[15:8]);
        step_check("R6", 1'b1, 1'b0, snap[7:0]);
        check("R6", crc_tab, 16'h0000);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule